// File: doc/BRIEF.md
# Privileged Trap and Interrupt Entry Unit

This unit sits beside the control and status register file of a hart that has three privilege levels: machine, supervisor and user. Each cycle it looks at the pending interrupt lines, the current privilege, the per-level interrupt-enable bits and the interrupt delegation mask. From these it reports whether an interrupt should be taken, and with which cause. The pipeline then turns that report into a trap request.

When a trap request arrives, the unit picks one of four outcomes:

- **Supervisor entry:** the trap is delegated to supervisor.
- **Machine entry:** the trap is handled at machine level.
- **Debug entry:** a software breakpoint diverts the hart into debug mode.
- **Redirect:** the hart is already in debug mode, so only the PC is redirected to a fixed debug-exception address.

One clock later it presents the new PC together with write strobes and the values the register file must store: the cause, the exception PC, the bad address, the saved enable bit, the previous privilege and the new privilege. It also raises a pulse that drops any outstanding load reservation, and a one-cycle TLB-flush strobe whenever privilege is written.

Privilege is encoded as user = 0, supervisor = 1, machine = 3. The value 2 on the privilege input is treated as user everywhere. The per-level vectors `ie_lvl` and `ebrk_en` are indexed by this encoding: bit 0 is user, bit 1 is supervisor, bit 3 is machine, and bit 2 is never selected.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, `upd_valid`, `m_wr`, `s_wr`, `dbg_wr`, `tval_wr`, `resv_clr`, `tlb_flush` and `nxt_pc` are all zero.
- R2: A pending interrupt whose `mideleg` bit is 0 is enabled when privilege is below machine, or when privilege is machine and `ie_lvl[3]` is 1.
- R3: A pending interrupt whose `mideleg` bit is 1 is enabled when privilege is user, or when privilege is supervisor and `ie_lvl[1]` is 1.
- R4: `irq_req` is 1 exactly when some interrupt is enabled. `irq_cause` then holds the lowest enabled index, with bit XLEN-1 set.
- R5: A trap goes to supervisor (`s_wr`) only when all of these hold; otherwise it goes to machine (`m_wr`):
  - privilege is user or supervisor;
  - the cause index (the cause with bit XLEN-1 cleared) is below XLEN;
  - the bit at that index is 1 in `mideleg` for an interrupt cause, or in `medeleg` for an exception cause.
- R6: On supervisor entry:
  - `nxt_pc` is `stvec` and `priv_new` is 1;
  - `out_cause` and `out_epc` carry the request;
  - `out_pie` is `ie_lvl` at the current privilege and `out_pp` is the old privilege;
  - `tval_wr` follows `trap_has_tval`.
- R7: On machine entry, the same fields are produced as in R6, except that `nxt_pc` is `mtvec` and `priv_new` is 3.
- R8: A trap whose cause is exactly 3 (breakpoint), taken when `ebrk_en` at the current privilege is 1, enters debug mode instead. It asserts `dbg_wr` with `dbg_code` = 1, `out_pp` = old privilege, `out_epc` = the trap PC, `priv_new` = 3, and `nxt_pc` = `DBG_ENTRY`.
- R9: If `dbg_active_code` is nonzero and R8 does not apply, `nxt_pc` is `DBG_TRAP`, and `m_wr`, `s_wr`, `dbg_wr`, `resv_clr` and `tlb_flush` all stay 0.
- R10:
  - `resv_clr` pulses on every supervisor or machine entry.
  - `tlb_flush` pulses on every supervisor, machine or debug entry, since each of these writes privilege.
  - Neither pulses on a redirect.
- R11: A privilege input of 2 behaves as user for interrupt enables, delegation, breakpoint enable selection and the recorded old privilege.
- R12: All trap outputs appear one cycle after `trap_valid`. Each strobe lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pending | input | XLEN | Pending interrupt lines |
| priv | input | 2 | Current privilege |
| ie_lvl | input | 4 | Interrupt-enable bit per privilege level |
| mideleg | input | XLEN | Interrupt delegation mask |
| medeleg | input | XLEN | Exception delegation mask |
| ebrk_en | input | 4 | Breakpoint-to-debug enable per privilege level |
| dbg_active_code | input | 3 | Recorded debug cause, nonzero while in debug mode |
| mtvec | input | XLEN | Machine trap vector |
| stvec | input | XLEN | Supervisor trap vector |
| trap_valid | input | 1 | Trap request |
| trap_cause | input | XLEN | Trap cause, bit XLEN-1 marks an interrupt |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_has_tval | input | 1 | Request carries a bad address |
| trap_tval | input | XLEN | Bad address |
| irq_req | output | 1 | An enabled interrupt is pending |
| irq_cause | output | XLEN | Cause for the winning interrupt |
| upd_valid | output | 1 | Trap outcome valid this cycle |
| nxt_pc | output | XLEN | New PC |
| m_wr | output | 1 | Write machine cause, EPC and status stack |
| s_wr | output | 1 | Write supervisor cause, EPC and status stack |
| dbg_wr | output | 1 | Write debug cause, debug PC and old privilege |
| tval_wr | output | 1 | Write bad address at the entered level |
| out_cause | output | XLEN | Cause to store |
| out_epc | output | XLEN | Exception or debug PC to store |
| out_tval | output | XLEN | Bad address to store |
| out_pie | output | 1 | Value for the saved-enable bit |
| out_pp | output | 2 | Old privilege to store |
| priv_new | output | 2 | New privilege |
| dbg_code | output | 3 | Debug cause code to store |
| resv_clr | output | 1 | Drop load reservation |
| tlb_flush | output | 1 | Privilege written, flush translations |

## Verification
The bench sweeps every privilege value against all sixteen enable combinations and a series of pending and delegation patterns. It thereby catches a design that ignores the privilege level when applying an enable, or that picks the highest pending index instead of the lowest.

Trap requests cover every privilege, exception and interrupt causes, and an exception index of 40. Index 40 is one that a design truncating the index to five bits would wrongly delegate to supervisor under an all-ones mask. The sweep also includes breakpoint-enable masks that are set only for the level a raw privilege of 2 would select, so a design that fails to fold 2 into user enters debug at the wrong time. Debug-active cases check that a redirect changes nothing but the PC: a design that still strobed a level write or a TLB flush would corrupt trap state during debug.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int XLEN = 32,
  parameter int unsigned DBG_ENTRY = 32'h0000_0800,
  parameter int unsigned DBG_TRAP  = 32'h0000_0808
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] irq_pending,
  input  logic [1:0]      priv,
  input  logic [3:0]      ie_lvl,
  input  logic [XLEN-1:0] mideleg,
  input  logic [XLEN-1:0] medeleg,
  input  logic [3:0]      ebrk_en,
  input  logic [2:0]      dbg_active_code,
  input  logic [XLEN-1:0] mtvec,
  input  logic [XLEN-1:0] stvec,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_epc,
  input  logic            trap_has_tval,
  input  logic [XLEN-1:0] trap_tval,
  output logic            irq_req,
  output logic [XLEN-1:0] irq_cause,
  output logic            upd_valid,
  output logic [XLEN-1:0] nxt_pc,
  output logic            m_wr,
  output logic            s_wr,
  output logic            dbg_wr,
  output logic            tval_wr,
  output logic [XLEN-1:0] out_cause,
  output logic [XLEN-1:0] out_epc,
  output logic [XLEN-1:0] out_tval,
  output logic            out_pie,
  output logic [1:0]      out_pp,
  output logic [1:0]      priv_new,
  output logic [2:0]      dbg_code,
  output logic            resv_clr,
  output logic            tlb_flush
);
  localparam int IW = $clog2(XLEN);
  localparam logic [XLEN-1:0] DBG_ENTRY_V = XLEN'(DBG_ENTRY);
  localparam logic [XLEN-1:0] DBG_TRAP_V  = XLEN'(DBG_TRAP);
  localparam logic [2:0] SWBP_CODE = 3'd1;

  logic [1:0] lvl;
  assign lvl = (priv == 2'd2) ? 2'd0 : priv;

  logic en_m, en_s;
  assign en_m = (lvl != 2'd3) | ie_lvl[3];
  assign en_s = (lvl == 2'd0) | ((lvl == 2'd1) & ie_lvl[1]);

  logic [XLEN-1:0] irq_en;
  assign irq_en = irq_pending & ((~mideleg & {XLEN{en_m}}) | (mideleg & {XLEN{en_s}}));

  logic [IW-1:0] irq_idx;
  always_comb begin
    irq_idx = '0;
    for (int i = XLEN-1; i >= 0; i--)
      if (irq_en[i]) irq_idx = IW'(i);
  end

  assign irq_req   = |irq_en;
  assign irq_cause = {1'b1, {(XLEN-1-IW){1'b0}}, irq_idx};

  logic is_irq, idx_ok, dbit, to_s, is_bp, redirect, normal;
  logic [XLEN-1:0] dsel;
  assign is_irq   = trap_cause[XLEN-1];
  assign idx_ok   = trap_cause[XLEN-2:IW] == '0;
  assign dsel     = is_irq ? mideleg : medeleg;
  assign dbit     = dsel[trap_cause[IW-1:0]];
  assign to_s     = !lvl[1] && idx_ok && dbit;
  assign is_bp    = (trap_cause == XLEN'(3)) && ebrk_en[lvl];
  assign redirect = !is_bp && (dbg_active_code != 3'd0);
  assign normal   = !is_bp && !redirect;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      m_wr      <= 1'b0;
      s_wr      <= 1'b0;
      dbg_wr    <= 1'b0;
      tval_wr   <= 1'b0;
      resv_clr  <= 1'b0;
      tlb_flush <= 1'b0;
      nxt_pc    <= '0;
      out_cause <= '0;
      out_epc   <= '0;
      out_tval  <= '0;
      out_pie   <= 1'b0;
      out_pp    <= 2'd0;
      priv_new  <= 2'd3;
      dbg_code  <= 3'd0;
    end else begin
      upd_valid <= trap_valid;
      m_wr      <= trap_valid && normal && !to_s;
      s_wr      <= trap_valid && normal && to_s;
      dbg_wr    <= trap_valid && is_bp;
      tval_wr   <= trap_valid && normal && trap_has_tval;
      resv_clr  <= trap_valid && normal;
      tlb_flush <= trap_valid && !redirect;
      if (trap_valid) begin
        nxt_pc    <= is_bp ? DBG_ENTRY_V : redirect ? DBG_TRAP_V : to_s ? stvec : mtvec;
        priv_new  <= (normal && to_s) ? 2'd1 : 2'd3;
        out_cause <= trap_cause;
        out_epc   <= trap_epc;
        out_tval  <= trap_tval;
        out_pie   <= ie_lvl[lvl];
        out_pp    <= lvl;
        dbg_code  <= is_bp ? SWBP_CODE : 3'd0;
      end
    end
  end
endmodule

module trap_entry_chk #(
  parameter int XLEN = 32,
  parameter int unsigned DBG_TRAP = 32'h0000_0808
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      priv,
  input logic [3:0]      ie_lvl,
  input logic [XLEN-1:0] mtvec,
  input logic [XLEN-1:0] stvec,
  input logic            trap_valid,
  input logic            irq_req,
  input logic            upd_valid,
  input logic [XLEN-1:0] nxt_pc,
  input logic            m_wr,
  input logic            s_wr,
  input logic            dbg_wr,
  input logic            resv_clr,
  input logic            tlb_flush,
  input logic [1:0]      priv_new
);
  AST_UPD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) upd_valid |-> $past(trap_valid)); // R12
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({m_wr, s_wr, dbg_wr})); // R5
  AST_M_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) m_wr |-> (priv_new == 2'd3 && nxt_pc == $past(mtvec))); // R7
  AST_S_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) s_wr |-> (priv_new == 2'd1 && nxt_pc == $past(stvec) && $past(priv) != 2'd3)); // R6
  AST_REDIRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (upd_valid && !tlb_flush) |-> (nxt_pc == XLEN'(DBG_TRAP) && !m_wr && !s_wr && !dbg_wr && !resv_clr)); // R9
  AST_FLUSH_IN_UPD: assert property (@(posedge clk) disable iff (!rst_n) tlb_flush |-> upd_valid); // R10
  AST_M_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (priv == 2'd3 && !ie_lvl[3]) |-> !irq_req); // R2
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .DBG_TRAP(DBG_TRAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv(priv), .ie_lvl(ie_lvl), .mtvec(mtvec), .stvec(stvec),
  .trap_valid(trap_valid), .irq_req(irq_req), .upd_valid(upd_valid), .nxt_pc(nxt_pc),
  .m_wr(m_wr), .s_wr(s_wr), .dbg_wr(dbg_wr), .resv_clr(resv_clr), .tlb_flush(tlb_flush),
  .priv_new(priv_new)
);

// File: tb/sim_trap_entry_unit.sv
module sim_trap_entry_unit;
  localparam int XLEN = 32;
  localparam logic [31:0] DBG_E = 32'h0000_0800;
  localparam logic [31:0] DBG_X = 32'h0000_0808;
  localparam logic [31:0] MTV = 32'h0000_1000;
  localparam logic [31:0] STV = 32'h0000_2000;

  logic clk = 0, rst_n = 0;
  logic [31:0] irq_pending = 0, mideleg = 0, medeleg = 0, mtvec = MTV, stvec = STV;
  logic [1:0] priv = 3;
  logic [3:0] ie_lvl = 0, ebrk_en = 0;
  logic [2:0] dbg_active_code = 0;
  logic trap_valid = 0, trap_has_tval = 0;
  logic [31:0] trap_cause = 0, trap_epc = 0, trap_tval = 0;
  logic irq_req, upd_valid, m_wr, s_wr, dbg_wr, tval_wr, out_pie, resv_clr, tlb_flush;
  logic [31:0] irq_cause, nxt_pc, out_cause, out_epc, out_tval;
  logic [1:0] out_pp, priv_new;
  logic [2:0] dbg_code;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN)) u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] cause_of(input int ci);
    if (ci <= 9) return 32'(ci);
    case (ci)
      10: return 32'd40;
      11: return 32'h8000_0001;
      12: return 32'h8000_0005;
      default: return 32'h8000_0009;
    endcase
  endfunction

  function automatic logic [3:0] ebrk_of(input int ev);
    case (ev)
      0: return 4'b0000;
      1: return 4'b1010;
      2: return 4'b0101;
      default: return 4'b0100;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 upd_valid", 32'(upd_valid), 0);
    check("R1 strobes", {26'd0, m_wr, s_wr, dbg_wr, tval_wr, resv_clr, tlb_flush}, 0);
    check("R1 nxt_pc", nxt_pc, 0);

    // interrupt sweep
    seed = 32'h1234_5678;
    for (int p = 0; p < 4; p++)
      for (int ie = 0; ie < 16; ie++)
        for (int k = 0; k < 8; k++) begin
          logic [1:0] ev;
          logic em, es, ereq;
          logic [31:0] en, ecause;
          seed = xs(seed);
          irq_pending = (k == 0) ? 32'd0 : (k[0] ? (seed & 32'h0000_0FF0) : seed);
          seed = xs(seed);
          mideleg = (k == 7) ? 32'hFFFF_FFFF : seed;
          priv = 2'(p);
          ie_lvl = 4'(ie);
          #1;
          ev = (p == 2) ? 2'd0 : 2'(p);
          em = (ev != 3) || ie_lvl[3];
          es = (ev == 0) || (ev == 1 && ie_lvl[1]);
          en = 0;
          for (int b = 0; b < 32; b++)
            if (irq_pending[b] && ((mideleg[b] && es) || (!mideleg[b] && em))) en[b] = 1;
          ereq = (en != 0);
          ecause = 0;
          for (int b = 31; b >= 0; b--) if (en[b]) ecause = 32'h8000_0000 | 32'(b);
          check(p == 2 ? "R11 R2/R3 irq_req" : "R2/R3 irq_req", 32'(irq_req), 32'(ereq));
          if (ereq) check("R4 irq_cause", irq_cause, ecause);
          @(negedge clk);
        end
    irq_pending = 0;

    // trap sweep
    for (int p = 0; p < 4; p++)
      for (int ci = 0; ci < 14; ci++)
        for (int dv = 0; dv < 2; dv++)
          for (int ev = 0; ev < 4; ev++)
            for (int gv = 0; gv < 2; gv++) begin
              logic [1:0] e;
              logic bp, rd, tos, isirq, bitd;
              logic [31:0] c, idx, dl, epc, epc_pc;
              logic [2:0] ewr;
              string tg;
              c = cause_of(ci);
              priv = 2'(p);
              ie_lvl = 4'(ci) ^ 4'(p);
              ebrk_en = ebrk_of(ev);
              dbg_active_code = gv ? 3'd2 : 3'd0;
              medeleg = dv ? 32'hFFFF_FFFF : 32'h0000_0222;
              mideleg = dv ? 32'hFFFF_FFFF : 32'h0000_00AA;
              trap_cause = c;
              trap_epc = 32'h4000_0000 + 32'(ci * 4);
              trap_has_tval = ci[0];
              trap_tval = 32'hBAD0_0000 | 32'(ci);
              trap_valid = 1;
              e = (p == 2) ? 2'd0 : 2'(p);
              bp = (c == 3) && ebrk_en[e];
              rd = !bp && gv != 0;
              isirq = c[31];
              idx = {1'b0, c[30:0]};
              dl = isirq ? mideleg : medeleg;
              bitd = (idx < 32) ? dl[idx[4:0]] : 1'b0;
              tos = (e <= 1) && (idx < 32) && bitd;
              if (bp) begin ewr = 3'b001; epc_pc = DBG_E; tg = "R8"; end
              else if (rd) begin ewr = 3'b000; epc_pc = DBG_X; tg = "R9"; end
              else if (tos) begin ewr = 3'b010; epc_pc = STV; tg = "R6"; end
              else begin ewr = 3'b100; epc_pc = MTV; tg = "R7"; end
              epc = trap_epc;
              @(negedge clk);
              trap_valid = 0;
              check("R12 upd_valid", 32'(upd_valid), 1);
              check(rd ? "R9 R5 targets" : "R5 targets", {29'd0, m_wr, s_wr, dbg_wr}, {29'd0, ewr});
              check({tg, " nxt_pc"}, nxt_pc, epc_pc);
              check("R10 tlb_flush", 32'(tlb_flush), 32'(!rd));
              check("R10 resv_clr", 32'(resv_clr), 32'(!rd && !bp));
              if (!rd) begin
                check({tg, " priv_new"}, 32'(priv_new), (ewr == 3'b010) ? 1 : 3);
                check({tg, " out_epc"}, out_epc, epc);
                check({tg, " out_pp"}, 32'(out_pp), 32'(e));
                if (p == 2) check("R11 old priv", 32'(out_pp), 0);
              end
              if (bp) check("R8 dbg_code", 32'(dbg_code), 1);
              if (!rd && !bp) begin
                check({tg, " out_cause"}, out_cause, c);
                check({tg, " out_pie"}, 32'(out_pie), 32'(ie_lvl[e]));
                check({tg, " tval_wr"}, 32'(tval_wr), 32'(ci[0]));
                if (ci[0]) check({tg, " out_tval"}, out_tval, trap_tval);
              end
              @(negedge clk);
              check("R12 pulse end", {29'd0, upd_valid, tlb_flush, m_wr | s_wr | dbg_wr}, 0);
            end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule